// File: doc/BRIEF.md
# CAN Controller Mode Handshake Unit

This unit sits between the CPU-facing control register of a CAN protocol controller and its protocol engine. The CPU sets or clears two request bits: one for sleep and one for configuration (init). The unit registers each request and decides when to grant it. It reports each grant on an acknowledge output. It also refuses CPU clears that come too early.

A sleep request is granted only while the controller runs normally and the bus is idle. While asleep, the controller can be woken by the CPU or by a dominant bit on the bus. Raising the init request aborts all traffic and forces the transmit pin recessive. When the init request is then released, the unit waits for the bus to go quiet before it declares itself synchronized. Quiet means one run of recessive bits, or 128 such runs when the controller is bus-off.

The unit also gates writes to the configuration registers. It emits a one-cycle pulse that clears the controller's other registers when init is entered.

The mode state machine has four states. INIT is the reset state and is held while init_req is 1. RESYNC waits for quiet after init is released. RUN is normal operation. SLEEP is the low-power state. The transitions are:
- any state to INIT when init_req is 1;
- INIT to RESYNC when init_req is 0;
- RESYNC to RUN when the quiet count is complete;
- RUN to SLEEP when sleep_req is 1 and the bus is idle;
- SLEEP to RUN when sleep_req is 0.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset, init_req=1, init_ack=1, sleep_req=0, sleep_ack=0, bus_synced=0 and regs_clear=0.
- R2: A control write (ctl_wr=1) with wr_init=1 sets init_req at the next edge. With wr_init=0 it clears init_req only if init_ack is 1 at that edge, and otherwise leaves it unchanged. init_ack follows init_req one edge later.
- R3: In RUN, sleep_ack rises one edge after a cycle with sleep_req=1, receiving=0 and tx_buffers_empty=1. If either idle condition is absent, it stays 0.
- R4: A control write with wr_sleep=1 while wake_pending=1 leaves sleep_req unchanged.
- R5: A control write with wr_sleep=0 clears sleep_req only if sleep_ack is 1 at that edge. sleep_ack falls one edge after sleep_req clears.
- R6: While sleep_ack=1 and wake_en=1, a sample with bit_tick=1 and rx_bit=0 (dominant) clears sleep_req at that edge. This holds even if a CPU write tries to set sleep_req in the same cycle.
- R7: In RESYNC, each bit_tick with rx_bit=1 (recessive) counts one bit and a dominant sample restarts the count. bus_synced rises at the edge that samples the 11th consecutive recessive bit when bus_off=0.
- R8: With bus_off=1, bus_synced rises only at the edge that completes the 128th run of 11 recessive bits. The run count restarts from zero after each completed run.
- R9: tx_pin is 1 (recessive) in the same cycle that init_req=1, cpu_stop=1, both cpu_wait and wait_disable are 1, or the mode is not RUN. Otherwise tx_pin equals tx_bit_in.
- R10: cfg_wr_grant equals cfg_wr_req only while init_req=1 and init_ack=1, and is 0 otherwise.
- R11: regs_clear pulses for exactly the first cycle in which init_ack is 1 after being 0. abort_xfer equals init_req.
- R12: Entering INIT from SLEEP drops sleep_ack in the same cycle that init_ack rises, and sleep_req keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | CPU write strobe for the mode request bits |
| wr_init | input | 1 | Init request value written |
| wr_sleep | input | 1 | Sleep request value written |
| wake_pending | input | 1 | Wake-up interrupt flag is pending |
| wake_en | input | 1 | Allow bus activity to end sleep |
| bit_tick | input | 1 | rx_bit holds a new bit sample this cycle |
| rx_bit | input | 1 | Sampled bus bit, 1 = recessive |
| receiving | input | 1 | A frame reception is in progress |
| tx_buffers_empty | input | 1 | All transmit buffers are empty |
| bus_off | input | 1 | Controller is in bus-off state |
| cpu_wait | input | 1 | CPU is in wait mode |
| wait_disable | input | 1 | Controller is stopped during CPU wait |
| cpu_stop | input | 1 | CPU is in stop mode |
| tx_bit_in | input | 1 | Transmit bit from the protocol engine |
| cfg_wr_req | input | 1 | Write attempt to a configuration register |
| init_req | output | 1 | Init request bit |
| init_ack | output | 1 | Init mode acknowledged |
| sleep_req | output | 1 | Sleep request bit |
| sleep_ack | output | 1 | Sleep mode acknowledged |
| bus_synced | output | 1 | Synchronized to the bus (RUN or SLEEP) |
| abort_xfer | output | 1 | Abort transfers in progress |
| regs_clear | output | 1 | One-cycle clear for the controller registers on init entry |
| cfg_wr_grant | output | 1 | Configuration write allowed |
| tx_pin | output | 1 | Transmit pin, 1 = recessive |

## Verification
The request bits change at the first edge after a control write. Each acknowledge and bus_synced change at the edge after the condition that causes them. regs_clear appears together with the rising init_ack. tx_pin, cfg_wr_grant and abort_xfer follow their inputs within the same cycle. A behavioural model advances at each rising edge from the inputs driven one time unit after the previous falling edge, so the model and the design see the same settled stimulus. All outputs are compared at the falling edge. Directed checks sample either in the same cycle, for the combinational paths, or after the edge counts given above, with margins around the 11-bit and 1408-bit windows.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [1:0] {
        MODE_INIT   = 2'd0,
        MODE_RESYNC = 2'd1,
        MODE_RUN    = 2'd2,
        MODE_SLEEP  = 2'd3
    } mode_e;

endpackage

// File: rtl/can_mode_req_regs.sv
module can_mode_req_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic wr_init,
    input  logic wr_sleep,
    input  logic wake_pending,
    input  logic wake_en,
    input  logic bit_tick,
    input  logic rx_bit,
    input  logic init_ack,
    input  logic sleep_ack,
    output logic init_req,
    output logic sleep_req
);

    logic init_nxt;
    logic sleep_nxt;
    logic bus_wake;

    always_comb begin
        bus_wake = sleep_ack & wake_en & bit_tick & ~rx_bit;

        init_nxt = init_req;
        if (ctl_wr) begin
            if (wr_init) begin
                init_nxt = 1'b1;
            end else if (init_ack) begin
                init_nxt = 1'b0;
            end
        end

        sleep_nxt = sleep_req;
        if (ctl_wr) begin
            if (wr_sleep) begin
                if (!wake_pending) begin
                    sleep_nxt = 1'b1;
                end
            end else if (sleep_ack) begin
                sleep_nxt = 1'b0;
            end
        end
        if (bus_wake) begin
            sleep_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_req  <= 1'b1;
            sleep_req <= 1'b0;
        end else begin
            init_req  <= init_nxt;
            sleep_req <= sleep_nxt;
        end
    end

endmodule

// File: rtl/can_resync_cnt.sv
module can_resync_cnt #(
    parameter int RUN_LEN     = 11,
    parameter int BUSOFF_RUNS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_tick,
    input  logic rx_bit,
    input  logic bus_off,
    output logic sync_done
);

    localparam int RW = $clog2(RUN_LEN + 1);
    localparam int OW = $clog2(BUSOFF_RUNS + 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LEN - 1);
    localparam logic [OW-1:0] OCC_LAST = OW'(BUSOFF_RUNS - 1);

    logic [RW-1:0] run_q;
    logic [OW-1:0] occ_q;
    logic          run_full;
    logic          occ_full;

    always_comb begin
        run_full  = bit_tick & rx_bit & (run_q == RUN_LAST);
        occ_full  = (occ_q == OCC_LAST);
        sync_done = enable & run_full & (~bus_off | occ_full);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            occ_q <= '0;
        end else if (!enable) begin
            run_q <= '0;
            occ_q <= '0;
        end else if (bit_tick) begin
            if (!rx_bit) begin
                run_q <= '0;
            end else if (run_full) begin
                run_q <= '0;
                if (!occ_full) begin
                    occ_q <= occ_q + 1'b1;
                end
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  init_req,
    input  logic  sleep_req,
    input  logic  bus_idle,
    input  logic  sync_done,
    output mode_e mode,
    output logic  regs_clear
);

    mode_e state_q;
    mode_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (init_req) begin
            state_d = MODE_INIT;
        end else begin
            unique case (state_q)
                MODE_INIT:   state_d = MODE_RESYNC;
                MODE_RESYNC: if (sync_done) state_d = MODE_RUN;
                MODE_RUN:    if (sleep_req && bus_idle) state_d = MODE_SLEEP;
                MODE_SLEEP:  if (!sleep_req) state_d = MODE_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_clear <= 1'b0;
        end else begin
            regs_clear <= (state_d == MODE_INIT) && (state_q != MODE_INIT);
        end
    end

    assign mode = state_q;

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
    import can_mode_pkg::*;
#(
    parameter int RUN_LEN     = 11,
    parameter int BUSOFF_RUNS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic wr_init,
    input  logic wr_sleep,
    input  logic wake_pending,
    input  logic wake_en,
    input  logic bit_tick,
    input  logic rx_bit,
    input  logic receiving,
    input  logic tx_buffers_empty,
    input  logic bus_off,
    input  logic cpu_wait,
    input  logic wait_disable,
    input  logic cpu_stop,
    input  logic tx_bit_in,
    input  logic cfg_wr_req,
    output logic init_req,
    output logic init_ack,
    output logic sleep_req,
    output logic sleep_ack,
    output logic bus_synced,
    output logic abort_xfer,
    output logic regs_clear,
    output logic cfg_wr_grant,
    output logic tx_pin
);

    mode_e mode;
    logic  sync_done;
    logic  bus_idle;
    logic  tx_force;

    assign bus_idle = ~receiving & tx_buffers_empty;

    can_mode_req_regs u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr       (ctl_wr),
        .wr_init      (wr_init),
        .wr_sleep     (wr_sleep),
        .wake_pending (wake_pending),
        .wake_en      (wake_en),
        .bit_tick     (bit_tick),
        .rx_bit       (rx_bit),
        .init_ack     (init_ack),
        .sleep_ack    (sleep_ack),
        .init_req     (init_req),
        .sleep_req    (sleep_req)
    );

    can_resync_cnt #(
        .RUN_LEN     (RUN_LEN),
        .BUSOFF_RUNS (BUSOFF_RUNS)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (mode == MODE_RESYNC),
        .bit_tick  (bit_tick),
        .rx_bit    (rx_bit),
        .bus_off   (bus_off),
        .sync_done (sync_done)
    );

    can_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_req   (init_req),
        .sleep_req  (sleep_req),
        .bus_idle   (bus_idle),
        .sync_done  (sync_done),
        .mode       (mode),
        .regs_clear (regs_clear)
    );

    always_comb begin
        init_ack     = (mode == MODE_INIT);
        sleep_ack    = (mode == MODE_SLEEP);
        bus_synced   = (mode == MODE_RUN) || (mode == MODE_SLEEP);
        abort_xfer   = init_req;
        cfg_wr_grant = cfg_wr_req & init_req & init_ack;
        tx_force     = init_req | cpu_stop | (cpu_wait & wait_disable)
                     | (mode != MODE_RUN);
        tx_pin       = tx_force ? 1'b1 : tx_bit_in;
    end

endmodule

// File: rtl/can_mode_chk.sv
module can_mode_chk (
    input logic clk,
    input logic rst_n,
    input logic ctl_wr,
    input logic wake_pending,
    input logic bit_tick,
    input logic rx_bit,
    input logic receiving,
    input logic tx_buffers_empty,
    input logic cpu_wait,
    input logic wait_disable,
    input logic cpu_stop,
    input logic cfg_wr_req,
    input logic init_req,
    input logic init_ack,
    input logic sleep_req,
    input logic sleep_ack,
    input logic bus_synced,
    input logic regs_clear,
    input logic cfg_wr_grant,
    input logic tx_pin
);

    assert_init_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_req) |-> $past(init_ack && ctl_wr));

    assert_sleep_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_ack) |-> $past(sleep_req && !receiving && tx_buffers_empty));

    assert_wake_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_req) |-> $past(!wake_pending && ctl_wr));

    assert_sleep_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_req) |-> $past(sleep_ack));

    assert_sync_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_synced) |-> $past(bit_tick && rx_bit));

    assert_tx_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req || cpu_stop || (cpu_wait && wait_disable)) |-> tx_pin);

    assert_cfg_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_grant |-> (init_req && init_ack && cfg_wr_req));

    assert_clear_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        regs_clear |=> !regs_clear);

    assert_ack_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_ack && sleep_ack));

endmodule

bind can_mode_ctrl can_mode_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .ctl_wr           (ctl_wr),
    .wake_pending     (wake_pending),
    .bit_tick         (bit_tick),
    .rx_bit           (rx_bit),
    .receiving        (receiving),
    .tx_buffers_empty (tx_buffers_empty),
    .cpu_wait         (cpu_wait),
    .wait_disable     (wait_disable),
    .cpu_stop         (cpu_stop),
    .cfg_wr_req       (cfg_wr_req),
    .init_req         (init_req),
    .init_ack         (init_ack),
    .sleep_req        (sleep_req),
    .sleep_ack        (sleep_ack),
    .bus_synced       (bus_synced),
    .regs_clear       (regs_clear),
    .cfg_wr_grant     (cfg_wr_grant),
    .tx_pin           (tx_pin)
);

// File: tb/sim_can_mode_ctrl.sv
`timescale 1ns/1ps
module sim_can_mode_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 0, wr_init = 0, wr_sleep = 0, wake_pending = 0, wake_en = 0;
    logic bit_tick = 1, rx_bit = 1, receiving = 0, tx_buffers_empty = 1, bus_off = 0;
    logic cpu_wait = 0, wait_disable = 0, cpu_stop = 0, tx_bit_in = 1, cfg_wr_req = 0;
    logic init_req, init_ack, sleep_req, sleep_ack, bus_synced;
    logic abort_xfer, regs_clear, cfg_wr_grant, tx_pin;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    can_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wr_init(wr_init),
        .wr_sleep(wr_sleep), .wake_pending(wake_pending), .wake_en(wake_en),
        .bit_tick(bit_tick), .rx_bit(rx_bit), .receiving(receiving),
        .tx_buffers_empty(tx_buffers_empty), .bus_off(bus_off),
        .cpu_wait(cpu_wait), .wait_disable(wait_disable), .cpu_stop(cpu_stop),
        .tx_bit_in(tx_bit_in), .cfg_wr_req(cfg_wr_req),
        .init_req(init_req), .init_ack(init_ack), .sleep_req(sleep_req),
        .sleep_ack(sleep_ack), .bus_synced(bus_synced), .abort_xfer(abort_xfer),
        .regs_clear(regs_clear), .cfg_wr_grant(cfg_wr_grant), .tx_pin(tx_pin)
    );

    // Behavioural reference: mode 0 init, 1 resync, 2 run, 3 sleep
    int m_mode, n_mode, m_run, n_run, m_occ, n_occ;
    bit m_init, n_init, m_sleep, n_sleep, m_clr;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_init = 1; m_sleep = 0; m_run = 0; m_occ = 0; m_clr = 0;
        end else begin
            n_init = m_init;
            if (ctl_wr) begin
                if (wr_init) n_init = 1;
                else if (m_mode == 0) n_init = 0;
            end
            n_sleep = m_sleep;
            if (ctl_wr) begin
                if (wr_sleep) begin
                    if (!wake_pending) n_sleep = 1;
                end else if (m_mode == 3) n_sleep = 0;
            end
            if (m_mode == 3 && wake_en && bit_tick && !rx_bit) n_sleep = 0;
            n_mode = m_mode; n_run = m_run; n_occ = m_occ;
            if (m_init) n_mode = 0;
            else begin
                case (m_mode)
                    0: n_mode = 1;
                    1: if (bit_tick) begin
                        if (!rx_bit) n_run = 0;
                        else if (m_run + 1 == 11) begin
                            n_run = 0;
                            if (!bus_off || m_occ + 1 == 128) n_mode = 2;
                            else n_occ = m_occ + 1;
                        end else n_run = m_run + 1;
                    end
                    2: if (m_sleep && !receiving && tx_buffers_empty) n_mode = 3;
                    default: if (!m_sleep) n_mode = 2;
                endcase
            end
            if (n_mode != 1) begin n_run = 0; n_occ = 0; end
            m_clr = (n_mode == 0) && (m_mode != 0);
            m_mode = n_mode; m_init = n_init; m_sleep = n_sleep;
            m_run = n_run; m_occ = n_occ;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 init_req", init_req, m_init);
            chk("R2 init_ack", init_ack, m_mode == 0);
            chk("R5 sleep_req", sleep_req, m_sleep);
            chk("R3 sleep_ack", sleep_ack, m_mode == 3);
            chk("R7 bus_synced", bus_synced, m_mode >= 2);
            chk("R11 abort_xfer", abort_xfer, m_init);
            chk("R11 regs_clear", regs_clear, m_clr);
            chk("R10 cfg_wr_grant", cfg_wr_grant, cfg_wr_req && m_init && m_mode == 0);
            chk("R9 tx_pin", tx_pin,
                (m_init || cpu_stop || (cpu_wait && wait_disable) || m_mode != 2) ? 1'b1 : tx_bit_in);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic i, input logic s);
        ctl_wr = 1; wr_init = i; wr_sleep = s;
        step(1);
        ctl_wr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 init_req", init_req, 1'b1);
        chk("R1 init_ack", init_ack, 1'b1);
        chk("R1 sleep_req", sleep_req, 1'b0);
        chk("R1 sleep_ack", sleep_ack, 1'b0);
        chk("R1 bus_synced", bus_synced, 1'b0);
        chk("R1 regs_clear", regs_clear, 1'b0);
        #1 rst_n = 1;
        step(2);

        // leave init and resync with a dominant interruption
        wr(0, 0);
        step(2);
        rx_bit = 1; step(5);
        rx_bit = 0; step(1);
        rx_bit = 1; step(8);
        chk("R7 not yet synced", bus_synced, 1'b0);
        step(4);
        chk("R7 synced", bus_synced, 1'b1);

        // transmit pin forcing
        tx_bit_in = 0; step(1);
        chk("R9 follow", tx_pin, 1'b0);
        cpu_wait = 1; #1 chk("R9 wait only", tx_pin, 1'b0);
        wait_disable = 1; #1 chk("R9 wait disable", tx_pin, 1'b1);
        cpu_wait = 0; wait_disable = 0; cpu_stop = 1; #1 chk("R9 stop", tx_pin, 1'b1);
        cpu_stop = 0; tx_bit_in = 1; step(1);

        // sleep entry needs idle; early clear ignored
        receiving = 1;
        wr(0, 1); step(3);
        chk("R3 busy rx no ack", sleep_ack, 1'b0);
        wr(0, 0); step(1);
        chk("R5 early clear ignored", sleep_req, 1'b1);
        receiving = 0; tx_buffers_empty = 0; step(3);
        chk("R3 tx busy no ack", sleep_ack, 1'b0);
        tx_buffers_empty = 1; step(2);
        chk("R3 ack", sleep_ack, 1'b1);

        // wake by bus activity
        wake_en = 1; rx_bit = 0; step(1);
        rx_bit = 1;
        chk("R6 wake clears request", sleep_req, 1'b0);
        step(1);
        chk("R6 ack drops", sleep_ack, 1'b0);
        wake_en = 0;

        // pending wake blocks sleep set
        wake_pending = 1;
        wr(0, 1); step(2);
        chk("R4 set blocked", sleep_req, 1'b0);
        wake_pending = 0;

        // sleep, then init request from sleep
        wr(0, 1); step(2);
        chk("R3 asleep again", sleep_ack, 1'b1);
        ctl_wr = 1; wr_init = 1; wr_sleep = 1; step(1);
        chk("R9 forced on request", tx_pin, 1'b1);
        wr_init = 0; step(1);
        ctl_wr = 0;
        chk("R2 clear before ack ignored", init_req, 1'b1);
        chk("R2 ack", init_ack, 1'b1);
        chk("R12 sleep_ack low", sleep_ack, 1'b0);
        chk("R12 sleep_req kept", sleep_req, 1'b1);
        chk("R11 clear pulse", regs_clear, 1'b1);
        chk("R11 abort", abort_xfer, 1'b1);
        step(1);
        chk("R11 pulse ends", regs_clear, 1'b0);

        // configuration gate
        cfg_wr_req = 1; #1 chk("R10 grant in init", cfg_wr_grant, 1'b1);

        // bus-off resync: 128 runs of 11
        bus_off = 1; rx_bit = 1;
        wr(0, 1);
        chk("R10 no grant outside init", cfg_wr_grant, 1'b0);
        cfg_wr_req = 0;
        step(1390);
        chk("R8 not synced before 128 runs", bus_synced, 1'b0);
        step(40);
        chk("R8 synced after 128 runs", bus_synced, 1'b1);
        bus_off = 0;

        wr(0, 0); step(3);
        chk("R5 clear after ack", sleep_req, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule